// File: doc/BRIEF.md
# Escaped Byte Stream Splitter

This block accepts a single byte stream in which one reserved byte value, 0xA5, acts as an in-band escape. It separates the stream into two output streams. Bytes that are not escaped pass straight through to the primary output. A byte preceded by an unpaired escape is steered to the secondary output, and a pair of escapes collapses into one literal 0xA5 on the primary output.

The input and both outputs are valid/ready handshakes. The path is combinational: the byte offered at the input appears, in the same cycle, on whichever output it belongs to. The input stalls while that output is not ready. The only stored state is a single flag. It records that the previous accepted byte was an escape that has not yet been paired. An opening escape never has to wait for either output, because it is consumed without producing anything.

Top module: `esc_demux`

## Requirements
- R1: An input byte other than 0xA5 that arrives with no escape pending appears unchanged on output A (aData), and nothing appears on output B.
- R2: An escape (0xA5) followed by a byte other than 0xA5 produces nothing for the escape and delivers the second byte on output B (bData). Output B never carries the value 0xA5.
- R3: Two escapes in a row produce exactly one 0xA5 on output A.
- R4: Escapes are paired strictly left to right. Three escapes followed by byte X give 0xA5 on A, then X on B. Four escapes followed by X give 0xA5, 0xA5, X on A and nothing on B.
- R5: The input 01,02,A5,03,04,A5,A5,05,06,A5,A5,A5,07,08,A5,A5,A5,A5,09,0A (hex) produces A = 01,02,04,A5,05,06,A5,08,A5,A5,09,0A and B = 03,07, under any pattern of valid gaps and ready stalls.
- R6: While the byte being offered targets an output whose ready is low, inReady is low. No byte is lost or duplicated through such a stall.
- R7: An opening escape (an input 0xA5 with no escape pending) is accepted in the cycle it is offered, whatever the state of aReady and bReady. No output valid is raised for it.
- R8: A synchronous reset (rst high at a clock edge) clears the pending escape. A non-escape byte offered after reset goes to output A even if the last byte accepted before reset was an opening escape.
- R9: While an output's valid is high and its ready is low, its valid stays high and its data stays unchanged on the next cycle, provided the source holds its byte while inReady is low.
- R10: aValid and bValid are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inData | input | 8 | Incoming escaped byte |
| inValid | input | 1 | Incoming byte is present |
| inReady | output | 1 | Incoming byte is taken at this edge |
| aData | output | 8 | Primary output byte |
| aValid | output | 1 | Primary output byte is present |
| aReady | input | 1 | Primary consumer takes the byte |
| bData | output | 8 | Secondary (escaped) output byte |
| bValid | output | 1 | Secondary output byte is present |
| bReady | input | 1 | Secondary consumer takes the byte |

## Verification
Directed streams try each pairing case on its own: a plain byte, escape plus byte, an escape pair, and runs of three and four escapes. Together they separate routing errors from pairing errors. Running the reference sequence under full readiness and again under random stalls separates a correct parser from one that loses or repeats bytes when the pending flag and backpressure interact. A directed check with both outputs stalled distinguishes whether an opening escape is swallowed freely or blocked by the wrong ready. A check across reset shows whether the pending flag is cleared. Long random streams dense in 0xA5 are compared against a bench model of the pairing rule.

// File: rtl/esc_pkg.sv
package esc_pkg;
  // Routing decision for the byte currently offered at the input.
  typedef struct packed {
    logic toA;     // byte is emitted on the primary output
    logic toB;     // byte is emitted on the secondary output
    logic swallow; // byte is consumed and emits nothing
  } route_t;
endpackage

// File: rtl/esc_ctrl.sv
module esc_ctrl
  import esc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   inValid,
  input  logic   isMark,
  input  logic   aReady,
  input  logic   bReady,
  output route_t route,
  output logic   inReady
);
  logic pending;
  logic accept;

  always_comb begin
    route = '0;
    if (!pending) begin
      if (isMark) route.swallow = 1'b1;
      else        route.toA     = 1'b1;
    end else begin
      if (isMark) route.toA = 1'b1;
      else        route.toB = 1'b1;
    end
  end

  assign inReady = route.swallow | (route.toA & aReady) | (route.toB & bReady);
  assign accept  = inValid & inReady;

  always_ff @(posedge clk) begin
    if (rst)         pending <= 1'b0;
    else if (accept) pending <= route.swallow;
  end
endmodule

// File: rtl/esc_path.sv
module esc_path
  import esc_pkg::*;
#(
  parameter int              DATA_W = 8,
  parameter logic [DATA_W-1:0] MARK = 8'hA5
) (
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  input  route_t            route,
  output logic              isMark,
  output logic [DATA_W-1:0] aData,
  output logic              aValid,
  output logic [DATA_W-1:0] bData,
  output logic              bValid
);
  assign isMark = (inData == MARK);
  // A doubled marker emits the marker value itself, which is the input byte.
  assign aData  = inData;
  assign bData  = inData;
  assign aValid = inValid & route.toA;
  assign bValid = inValid & route.toB;
endmodule

// File: rtl/esc_demux.sv
module esc_demux
  import esc_pkg::*;
#(
  parameter int              DATA_W = 8,
  parameter logic [DATA_W-1:0] MARK = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic [DATA_W-1:0] aData,
  output logic              aValid,
  input  logic              aReady,
  output logic [DATA_W-1:0] bData,
  output logic              bValid,
  input  logic              bReady
);
  route_t route;
  logic   isMark;

  esc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .isMark(isMark),
    .aReady(aReady), .bReady(bReady), .route(route), .inReady(inReady)
  );

  esc_path #(.DATA_W(DATA_W), .MARK(MARK)) u_path (
    .inData(inData), .inValid(inValid), .route(route), .isMark(isMark),
    .aData(aData), .aValid(aValid), .bData(bData), .bValid(bValid)
  );
endmodule

// File: rtl/esc_demux_chk.sv
module esc_demux_chk #(
  parameter int              DATA_W = 8,
  parameter logic [DATA_W-1:0] MARK = 8'hA5
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] inData,
  input logic              inValid,
  input logic              inReady,
  input logic [DATA_W-1:0] aData,
  input logic              aValid,
  input logic              aReady,
  input logic [DATA_W-1:0] bData,
  input logic              bValid,
  input logic              bReady
);
  p_one_output_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({aValid, bValid}));

  p_stall_a_r6: assert property (@(posedge clk) disable iff (rst)
    (aValid && !aReady) |-> !inReady);

  p_stall_b_r6: assert property (@(posedge clk) disable iff (rst)
    (bValid && !bReady) |-> !inReady);

  p_swallow_free_r7: assert property (@(posedge clk) disable iff (rst)
    (inValid && !aValid && !bValid) |-> inReady);

  p_b_no_mark_r2: assert property (@(posedge clk) disable iff (rst)
    bValid |-> (bData != MARK));

  p_reset_clears_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && inValid && inData != MARK) |-> (aValid && !bValid));

  p_hold_a_r9: assert property (@(posedge clk) disable iff (rst)
    (aValid && !aReady) |=> (aValid && $stable(aData)));

  p_hold_b_r9: assert property (@(posedge clk) disable iff (rst)
    (bValid && !bReady) |=> (bValid && $stable(bData)));
endmodule

bind esc_demux esc_demux_chk #(.DATA_W(DATA_W), .MARK(MARK)) u_chk (.*);

// File: tb/tb_esc_demux.sv
module tb_esc_demux;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [7:0] aData;
  logic       aValid;
  logic       aReady = 1'b0;
  logic [7:0] bData;
  logic       bValid;
  logic       bReady = 1'b0;

  int total = 0;
  int bad   = 0;

  logic [7:0] stim[$];
  logic [7:0] expA[$];
  logic [7:0] expB[$];
  logic [7:0] gotA[$];
  logic [7:0] gotB[$];

  always #2 clk = ~clk;

  esc_demux dut (
    .clk(clk), .rst(rst), .inData(inData), .inValid(inValid), .inReady(inReady),
    .aData(aData), .aValid(aValid), .aReady(aReady),
    .bData(bData), .bValid(bValid), .bReady(bReady)
  );

  task automatic check(input string req, input logic ok, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Model of the pairing rule, independent of the design.
  task automatic buildExp();
    logic pend = 1'b0;
    expA.delete(); expB.delete();
    foreach (stim[i]) begin
      if (!pend) begin
        if (stim[i] == 8'hA5) pend = 1'b1;
        else expA.push_back(stim[i]);
      end else begin
        pend = 1'b0;
        if (stim[i] == 8'hA5) expA.push_back(8'hA5);
        else expB.push_back(stim[i]);
      end
    end
  endtask

  task automatic cmpQ(input string req, input string ch,
                      ref logic [7:0] got[$], ref logic [7:0] exp[$]);
    int mis = -1;
    if (got.size() == exp.size()) begin
      foreach (got[i]) if (mis < 0 && got[i] != exp[i]) mis = i;
      if (mis < 0) check(req, 1'b1, ch, 0, 0);
      else check(req, 1'b0, {ch, " byte mismatch"}, int'(got[mis]), int'(exp[mis]));
    end else begin
      check(req, 1'b0, {ch, " length"}, got.size(), exp.size());
    end
  endtask

  task automatic doReset();
    @(posedge clk); #1;
    rst = 1'b1; inValid = 1'b0;
    @(posedge clk); #1;
    rst = 1'b0;
  endtask

  task automatic runStream(input string req, input int rdyPct, input int vldPct);
    int idx = 0;
    int stallBad = 0;
    int freeBad = 0;
    int holdBad = 0;
    logic acc;
    logic holdA = 1'b0, holdB = 1'b0;
    logic [7:0] prevA = '0, prevB = '0;
    gotA.delete(); gotB.delete();
    buildExp();
    doReset();
    inData  = stim[0];
    inValid = (($urandom % 100) < vldPct);
    aReady  = (($urandom % 100) < rdyPct);
    bReady  = (($urandom % 100) < rdyPct);
    while (idx < stim.size()) begin
      @(negedge clk);
      if (aValid && aReady) gotA.push_back(aData);
      if (bValid && bReady) gotB.push_back(bData);
      if ((aValid && !aReady && inReady) || (bValid && !bReady && inReady)) stallBad++;
      if (inValid && !aValid && !bValid && !inReady) freeBad++;
      if (holdA && !(aValid && aData == prevA)) holdBad++;
      if (holdB && !(bValid && bData == prevB)) holdBad++;
      holdA = aValid && !aReady; prevA = aData;
      holdB = bValid && !bReady; prevB = bData;
      acc = inValid && inReady;
      @(posedge clk); #1;
      if (acc) idx++;
      if (idx >= stim.size()) begin
        inValid = 1'b0;
      end else begin
        if (acc || !inValid) inValid = (($urandom % 100) < vldPct);
        inData = stim[idx];
        aReady = (($urandom % 100) < rdyPct);
        bReady = (($urandom % 100) < rdyPct);
      end
    end
    cmpQ(req, "output A", gotA, expA);
    cmpQ(req, "output B", gotB, expB);
    check("R6", stallBad == 0, "input taken while target stalled", stallBad, 0);
    check("R7", freeBad == 0, "opening escape not taken", freeBad, 0);
    check("R9", holdBad == 0, "stalled output changed", holdBad, 0);
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    doReset();
    // Reset state: no outputs valid.
    @(negedge clk);
    check("R1", !aValid && !bValid, "valid after reset", {aValid, bValid}, 0);

    // R1: plain bytes
    stim = '{8'h01, 8'h02, 8'h7F, 8'h00, 8'hFF};
    runStream("R1", 100, 100);
    // R2: escape then byte
    stim = '{8'hA5, 8'h03, 8'h11, 8'hA5, 8'h44};
    runStream("R2", 100, 100);
    // R3: doubled escape
    stim = '{8'h10, 8'hA5, 8'hA5, 8'h20};
    runStream("R3", 100, 100);
    // R4: three and four escapes
    stim = '{8'hA5, 8'hA5, 8'hA5, 8'h5C};
    runStream("R4", 100, 100);
    stim = '{8'hA5, 8'hA5, 8'hA5, 8'hA5, 8'h5C};
    runStream("R4", 100, 100);
    // R5: reference sequence, clean and stalled
    stim = '{8'h01, 8'h02, 8'hA5, 8'h03, 8'h04, 8'hA5, 8'hA5, 8'h05, 8'h06, 8'hA5,
             8'hA5, 8'hA5, 8'h07, 8'h08, 8'hA5, 8'hA5, 8'hA5, 8'hA5, 8'h09, 8'h0A};
    runStream("R5", 100, 100);
    runStream("R5", 50, 70);
    check("R5", expA.size() == 12 && expB.size() == 2, "model sizes",
          expA.size() * 16 + expB.size(), 12 * 16 + 2);

    // R7 / R6 directed: both outputs stalled
    doReset();
    aReady = 1'b0; bReady = 1'b0; inValid = 1'b1; inData = 8'hA5;
    @(negedge clk);
    check("R7", inReady && !aValid && !bValid, "opening escape with outputs stalled",
          {inReady, aValid, bValid}, 3'b100);
    @(posedge clk); #1;
    inData = 8'h03;
    @(negedge clk);
    check("R6", !inReady && bValid && bData == 8'h03, "escaped byte stalls on B",
          {inReady, bValid}, 2'b01);
    @(posedge clk); #1;
    bReady = 1'b1;
    @(negedge clk);
    check("R6", inReady && bValid && bData == 8'h03, "escaped byte released",
          {inReady, bValid}, 2'b11);
    @(posedge clk); #1;
    inValid = 1'b0;

    // R8: pending escape cleared by reset
    doReset();
    aReady = 1'b1; bReady = 1'b1; inValid = 1'b1; inData = 8'hA5;
    @(posedge clk); #1;
    inValid = 1'b0; rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0; inValid = 1'b1; inData = 8'h33;
    @(negedge clk);
    check("R8", aValid && !bValid && aData == 8'h33, "byte after reset routed",
          {aValid, bValid}, 2'b10);
    @(posedge clk); #1;
    inValid = 1'b0;

    // Random streams dense in escapes
    for (int s = 0; s < 4; s++) begin
      stim.delete();
      for (int k = 0; k < 80; k++)
        stim.push_back((($urandom % 100) < 35) ? 8'hA5 : 8'($urandom));
      if (stim[stim.size()-1] == 8'hA5) stim.push_back(8'h42);
      runStream("R4", 40 + s * 15, 60 + s * 10);
    end
    // R10 spot check at idle
    @(negedge clk);
    check("R10", !(aValid && bValid), "both valids", {aValid, bValid}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule